// File: doc/BRIEF.md
# Parking Round-Robin Bus Arbiter

This block is the central arbiter for a shared synchronous bus with several masters. Each master has its own request line and its own grant bit. The arbiter grants the bus to one master at a time. A grant covers a single transaction. When the granted master starts a transaction, the arbiter picks the next owner at once, while the current transfer is still running, so the handover adds no idle cycles.

The arbiter sees one input from the bus, `bus_idle`. A transaction start is the point where `bus_idle` is high at one clock edge and low at the next. The master that holds the grant at that edge owns the new transaction. When nobody requests, the grant stays where it was, so the bus is parked on the last owner. That master can begin its next transaction without waiting for a grant. Fairness comes from a rotation pointer. Each time a transaction starts, the pointer moves to the position just after its owner.

The number of masters and the winner-search circuit are parameters. The search can be a wrap-around scan or a masked lowest-bit priority pick, and both give the same winner.

Top module: `bus_park_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `gnt` equals 1: only master 0 holds the grant, and the rotation pointer starts at position 1.
- R2: After reset, exactly one bit of `gnt` is set in every cycle.
- R3: If the grant holder's request bit is set at a clock edge that is not a transaction start, `gnt` is unchanged after that edge.
- R4: If `req` is all zero at a clock edge, `gnt` is unchanged after that edge. This holds at a transaction start as well. The bus therefore stays parked on the last holder.
- R5: A parked master that raises its request finds its grant bit already set in the same cycle. It keeps the grant up to and including the cycle in which its transaction starts.
- R6: At an edge that is not a transaction start, if the holder is not requesting and another master is, `gnt` moves after that edge to the first requester. The search starts at the rotation pointer, goes toward higher indices and wraps past N_MASTERS-1 to 0.
- R7: A transaction start is an edge where `bus_idle` was 1 at the previous edge and is 0 now. At such an edge, the pointer becomes owner+1 modulo N_MASTERS. If any request is set, `gnt` moves to the first requester searched from the new pointer, and it does so while `bus_idle` is still low.
- R8: A master that keeps requesting receives the grant before more than N_MASTERS-1 transactions owned by other masters have started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_MASTERS | Request bit per master |
| bus_idle | input | 1 | High while no transaction is in progress on the bus |
| gnt | output | N_MASTERS | One-hot grant, registered |

## Verification
The assertions and the ownership rule assume two things about the masters. A master pulls `bus_idle` low only in the cycle right after one in which it held the grant, had its request set, and saw the bus idle. As a result, the grant holder at a detected start is always the owner of that transaction. The stimulus keeps to this. The bus model starts a transaction only when the current grant holder's request was sampled high with the bus idle. Random requests are held until their transaction starts, so the fairness bound is tested under steady contention and not only under requests that drop away early.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

   localparam int MAX_MASTERS = 8;

   // Index of the single set bit (lowest one if several are set).
   function automatic int onehot_to_index(logic [MAX_MASTERS-1:0] v);
      int idx;
      idx = 0;
      for (int i = MAX_MASTERS - 1; i >= 0; i--) begin
         if (v[i]) idx = i;
      end
      return idx;
   endfunction

   // Increment modulo n.
   function automatic int wrap_inc(int idx, int n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/bpa_rr_pick.sv
module bpa_rr_pick #(
   parameter int N_MASTERS = 4,
   parameter int PICK_IMPL = 0,
   localparam int IW = $clog2(N_MASTERS)
) (
   input  logic [N_MASTERS-1:0] req,
   input  logic [IW-1:0]        base,
   output logic [N_MASTERS-1:0] win,
   output logic                 hit
);

   generate
      if (PICK_IMPL == 0) begin : g_scan
         // Walk from base upward with wrap; first set bit wins.
         always_comb begin
            logic [IW-1:0] j;
            win = '0;
            hit = 1'b0;
            for (int k = 0; k < N_MASTERS; k++) begin
               j = IW'((int'(base) + k) % N_MASTERS);
               if (!hit && req[j]) begin
                  win[j] = 1'b1;
                  hit    = 1'b1;
               end
            end
         end
      end else begin : g_mask
         // Upper half (at or above base) first, else whole vector;
         // lowest set bit isolated by two's complement.
         logic [N_MASTERS-1:0] upper_mask;
         logic [N_MASTERS-1:0] masked;
         logic [N_MASTERS-1:0] src;
         always_comb begin
            upper_mask = ~((N_MASTERS'(1) << base) - N_MASTERS'(1));
            masked     = req & upper_mask;
            src        = (|masked) ? masked : req;
            win        = src & (~src + N_MASTERS'(1));
            hit        = |req;
         end
      end
   endgenerate

endmodule

// File: rtl/bpa_start_detect.sv
module bpa_start_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_idle,
   output logic start
);

   logic idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle_q <= 1'b1;
      else        idle_q <= bus_idle;
   end

   // Idle at the previous edge, busy now: a new transaction began.
   assign start = idle_q & ~bus_idle;

endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter #(
   parameter int N_MASTERS = 4,
   parameter int PICK_IMPL = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req,
   input  logic                 bus_idle,
   output logic [N_MASTERS-1:0] gnt
);

   localparam int IW = $clog2(N_MASTERS);

   generate
      if (N_MASTERS < 2 || N_MASTERS > bpa_pkg::MAX_MASTERS) begin : g_bad_count
         $error("bus_park_arbiter: N_MASTERS must lie in 2..8");
      end
      if (PICK_IMPL != 0 && PICK_IMPL != 1) begin : g_bad_impl
         $error("bus_park_arbiter: PICK_IMPL must be 0 or 1");
      end
   endgenerate

   logic [N_MASTERS-1:0] gnt_q;
   logic [IW-1:0]        ptr_q;
   logic [IW-1:0]        owner_idx;
   logic [IW-1:0]        after_owner;
   logic [IW-1:0]        base_sel;
   logic [N_MASTERS-1:0] win;
   logic                 hit;
   logic                 start;
   logic                 holder_req;

   bpa_start_detect u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_idle (bus_idle),
      .start    (start)
   );

   always_comb begin
      owner_idx   = IW'(bpa_pkg::onehot_to_index(bpa_pkg::MAX_MASTERS'(gnt_q)));
      after_owner = IW'(bpa_pkg::wrap_inc(int'(owner_idx), N_MASTERS));
      // On a start the search begins just past the new owner; otherwise
      // it uses the stored rotation pointer.
      base_sel    = start ? after_owner : ptr_q;
      holder_req  = |(req & gnt_q);
   end

   bpa_rr_pick #(
      .N_MASTERS (N_MASTERS),
      .PICK_IMPL (PICK_IMPL)
   ) u_pick (
      .req  (req),
      .base (base_sel),
      .win  (win),
      .hit  (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q <= N_MASTERS'(1);
         ptr_q <= IW'(1);
      end else if (start) begin
         ptr_q <= after_owner;
         if (hit) gnt_q <= win;
      end else if (!holder_req && hit) begin
         gnt_q <= win;
      end
   end

   assign gnt = gnt_q;

endmodule

// File: rtl/bpa_checker.sv
module bpa_checker #(
   parameter int N_MASTERS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_MASTERS-1:0] req,
   input logic                 bus_idle,
   input logic [N_MASTERS-1:0] gnt
);

   logic idle_prev;
   logic start_seen;
   logic [3:0] wait_cnt [N_MASTERS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle_prev <= 1'b1;
      else        idle_prev <= bus_idle;
   end

   assign start_seen = idle_prev & ~bus_idle;

   // Starts owned by others while master i keeps requesting ungranted.
   generate
      for (genvar i = 0; i < N_MASTERS; i++) begin : g_wait
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                wait_cnt[i] <= '0;
            else if (!req[i] || gnt[i]) wait_cnt[i] <= '0;
            else if (start_seen && wait_cnt[i] != 4'hF)
               wait_cnt[i] <= wait_cnt[i] + 4'd1;
         end
         a_r8_fair: assert property (@(posedge clk) disable iff (!rst_n)
            int'(wait_cnt[i]) <= N_MASTERS - 1);
      end
   endgenerate

   always @(negedge clk) begin
      if (!rst_n) a_r1_reset_park: assert (gnt == N_MASTERS'(1));
   end

   a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt) == 1);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (|(req & gnt) && !start_seen) |=> $stable(gnt));

   a_r4_park: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> $stable(gnt));

   a_r6_move: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_seen && req != '0 && (req & gnt) == '0)
      |=> (gnt != $past(gnt)) && |(gnt & $past(req)));

   a_r7_handover: assert property (@(posedge clk) disable iff (!rst_n)
      (start_seen && req != '0) |=> |(gnt & $past(req)));

endmodule

bind bus_park_arbiter bpa_checker #(.N_MASTERS(N_MASTERS)) u_bpa_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .bus_idle (bus_idle),
   .gnt      (gnt)
);

// File: tb/bus_park_arbiter_test.sv
module bus_park_arbiter_test;

   localparam int NM         = 4;
   localparam int CLK_PERIOD = 10;

   logic          clk      = 1'b0;
   logic          rst_n    = 1'b0;
   logic [NM-1:0] req      = '0;
   logic          bus_idle = 1'b1;
   logic [NM-1:0] gnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_park_arbiter #(.N_MASTERS(NM), .PICK_IMPL(0)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .bus_idle (bus_idle),
      .gnt      (gnt)
   );

   int checks = 0;
   int misses = 0;
   bit done   = 1'b0;

   // Reference state, built from the requirements.
   int exp_own   = 0;
   int exp_ptr   = 1;
   bit idle_seen = 1'b1;
   int waitc [NM];

   int busy_left    = 0;
   int just_started = -1;

   function automatic int pick_from(logic [NM-1:0] r, int base);
      for (int k = 0; k < NM; k++) begin
         if (r[(base + k) % NM]) return (base + k) % NM;
      end
      return -1;
   endfunction

   function automatic int grant_index(logic [NM-1:0] g);
      for (int i = 0; i < NM; i++) if (g[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      int w;
      bit st;
      if (!rst_n) begin
         exp_own   = 0;
         exp_ptr   = 1;
         idle_seen = 1'b1;
         for (int i = 0; i < NM; i++) waitc[i] = 0;
      end else begin
         st = idle_seen && !bus_idle;
         if (st) begin
            for (int i = 0; i < NM; i++)
               if (req[i] && i != exp_own) waitc[i]++;
            exp_ptr = (exp_own + 1) % NM;
            w = pick_from(req, exp_ptr);
            if (w >= 0) exp_own = w;
         end else if (!req[exp_own]) begin
            w = pick_from(req, exp_ptr);
            if (w >= 0) exp_own = w;
         end
         for (int i = 0; i < NM; i++)
            if (!req[i] || exp_own == i) waitc[i] = 0;
         idle_seen = bus_idle;
      end
   end

   task automatic check(bit ok, string tag, logic [NM-1:0] act, logic [NM-1:0] expv);
      checks++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%b expected=%b", tag, act, expv);
      end
   endtask

   // One cycle: step to the negedge, compare against the reference.
   task automatic cyc();
      logic [NM-1:0] e;
      int worst;
      @(negedge clk);
      e = NM'(1) << exp_own;
      check(gnt == e, "R3/R6/R7 grant vs reference", gnt, e);
      check($countones(gnt) == 1, "R2 single grant", gnt, e);
      worst = 0;
      for (int i = 0; i < NM; i++) if (waitc[i] > worst) worst = waitc[i];
      check(worst <= NM - 1, "R8 wait bound", NM'(worst), NM'(NM - 1));
   endtask

   // Bus model: start only when the holder was seen requesting on an idle bus.
   task automatic bus_step();
      int g;
      just_started = -1;
      if (!bus_idle) begin
         busy_left--;
         if (busy_left <= 0) bus_idle = 1'b1;
      end else begin
         g = grant_index(gnt);
         if (g >= 0 && req[g] && ($urandom % 2) == 1) begin
            bus_idle     = 1'b0;
            busy_left    = 1 + int'($urandom % 4);
            just_started = g;
         end
      end
   endtask

   initial begin
      int prev_g;
      int g;
      void'($urandom(32'd20250611));

      // R1: reset state
      for (int n = 0; n < 3; n++) begin
         @(negedge clk);
         check(gnt == NM'(1), "R1 grant during reset", gnt, NM'(1));
      end
      rst_n = 1'b1;
      cyc();
      check(gnt == NM'(1), "R1 grant after reset", gnt, NM'(1));

      // R4: no requests, parked on master 0
      for (int n = 0; n < 4; n++) begin
         cyc();
         check(gnt == NM'(1), "R4 parked on master 0", gnt, NM'(1));
      end

      // R6: holder idle, master 2 requests -> grant moves one edge later
      req = NM'(4);
      cyc();
      check(gnt == NM'(4), "R6 move to requester", gnt, NM'(4));
      req = '0;
      for (int n = 0; n < 3; n++) begin
         cyc();
         check(gnt == NM'(4), "R4 parked on last holder", gnt, NM'(4));
      end

      // R5: parked master raises request, grant already present
      req = NM'(4);
      #1;
      check(gnt == NM'(4), "R5 zero-wait grant", gnt, NM'(4));
      cyc();
      check(gnt == NM'(4), "R5 grant held up to start", gnt, NM'(4));

      // R7: master 2 starts, master 0 requests -> handover during transfer
      bus_idle = 1'b0;
      req      = NM'(1);
      cyc();
      check(gnt == NM'(1) && !bus_idle, "R7 handover while busy", gnt, NM'(1));
      cyc();
      bus_idle = 1'b1;
      req      = '0;
      cyc();

      // R8 rule of R4: start with nobody requesting keeps grant on owner
      req = NM'(1);
      cyc();
      bus_idle = 1'b0;
      req      = '0;
      cyc();
      check(gnt == NM'(1), "R4 parked through start", gnt, NM'(1));
      bus_idle = 1'b1;
      cyc();

      // R8/R7: all request, grant must rotate one step per start
      req    = '1;
      prev_g = grant_index(gnt);
      for (int n = 0; n < 60; n++) begin
         cyc();
         g = grant_index(gnt);
         if (g != prev_g)
            check(g == (prev_g + 1) % NM, "R8 rotation order",
                  NM'(1) << g, NM'(1) << ((prev_g + 1) % NM));
         prev_g = g;
         bus_step();
      end

      // Random phase: held requests, random bus occupancy
      for (int n = 0; n < 4000; n++) begin
         cyc();
         bus_step();
         for (int i = 0; i < NM; i++) begin
            if (!req[i])                req[i] = (($urandom % 4) == 0);
            else if (i == just_started) req[i] = (($urandom % 4) == 0);
         end
      end

      req = '0;
      while (!bus_idle) begin
         cyc();
         bus_step();
      end
      for (int n = 0; n < 3; n++) cyc();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         misses++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
         $finish;
      end
   end

endmodule